// File: doc/BRIEF.md
# DDR SDRAM Command Bus Decoder with Bank-State Legality Checker

This block watches the control pins of a DDR SDRAM command bus and, on every rising clock edge, turns the sampled pin levels into a command class. It reports the class, the bank it addresses and the state of address bit 10 for each command. The report appears on the registered outputs one cycle after the edge that captured the pins.

Alongside the decoding, it keeps a model of the device state. This model covers the open or closed state of each bank, whether the power-up sequence has completed, and whether a read data burst is still running. With this model the block can judge each command against the current state. An illegal command raises a one-cycle error pulse with a 3-bit reason code, and it leaves the tracked state unchanged.

The block is meant to sit beside a memory controller or in a verification environment as a protocol monitor. It has no effect on the bus.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: When `cke` is high at a rising edge, the pins are decoded and reported one cycle later with `cmdValid`=1. With `csN` low, the levels of {`rasN`,`casN`,`weN`} map to `cmdKind` as follows: 111→0 (idle), 110→1 (burst stop), 101→2 (read), 100→3 (write), 011→4 (activate), 010→5 (precharge), 000→6 (mode set). Any other level combination gives 7 and is never flagged.
- R2: With `csN` high the command is reported as the idle class (`cmdKind`=0), the same as an explicit no-operation.
- R3: For read, write, activate and single-bank precharge, `cmdBank` carries `bankAddr`. For an all-bank precharge and for all other classes, `cmdBank` is 0. For read, write and precharge, `cmdA10` carries `addr10` (auto-precharge, or all banks for a precharge). For all other classes it is 0.
- R4: Until at least one precharge (single or all banks) and one legal mode set have been seen after reset, any activate, read or write is flagged with code 1.
- R5: A read or write to a closed bank is flagged with code 2.
- R6: An activate to a bank that is already open is flagged with code 3.
- R7: A mode set while any bank is open or while a read burst is active is flagged with code 4.
- R8: A burst stop while no read burst is active is flagged with code 5. A legal read starts a burst that is active at the following `burstLen` edges. A legal write or a legal burst stop ends the burst at once.
- R9: A legal activate opens its bank. A legal read or write with `addr10` high closes its bank after the access. A single-bank precharge closes its bank, and an all-bank precharge closes all eight.
- R10: An illegal command changes no bank state and no initialization progress.
- R11: When `cke` is low, the outputs report `cmdValid`=0 with all other outputs 0. The sampled command has no effect on bank state.
- R12: `errPulse` is high for exactly the report cycle of an illegal command, and `errCode` is 0 whenever `errPulse` is low. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock, rising edge samples |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin level |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankAddr | input | 3 | Bank address pins |
| addr10 | input | 1 | Address bit 10 |
| burstLen | input | 4 | Read burst length in clock edges |
| cmdValid | output | 1 | A command was decoded on the last edge |
| cmdKind | output | 3 | Decoded command class |
| cmdBank | output | 3 | Target bank of the decoded command |
| cmdA10 | output | 1 | Auto-precharge or all-bank flag |
| errPulse | output | 1 | Command was illegal in the current state |
| errCode | output | 3 | Reason for the error |

## Verification
Two functions can act on the same edge: the countdown of the read burst, and the judgement of a burst stop or mode set that depends on that burst. The bench issues a read and then a burst stop exactly on the last edge of the burst window, where the stop must be accepted. A second read is followed by a burst stop one edge past the window, where the stop must be flagged with code 5. A read with auto-precharge is followed at once by a mode set. Its bank is already closed, but the burst is still running, so the mode set must be flagged. A later mode set, issued after the window has passed, must be accepted. The scoreboard predicts each report from a behavioural model that steps on every clock, and it compares the prediction with the outputs one cycle after each edge.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    KIND_IDLE  = 3'd0,
    KIND_BSTOP = 3'd1,
    KIND_READ  = 3'd2,
    KIND_WRITE = 3'd3,
    KIND_ACT   = 3'd4,
    KIND_PRE   = 3'd5,
    KIND_MODE  = 3'd6,
    KIND_OTHER = 3'd7
  } cmdKind_e;

  localparam logic [2:0] ERR_NONE     = 3'd0;
  localparam logic [2:0] ERR_NOINIT   = 3'd1;
  localparam logic [2:0] ERR_CLOSED   = 3'd2;
  localparam logic [2:0] ERR_OPEN     = 3'd3;
  localparam logic [2:0] ERR_MODEBUSY = 3'd4;
  localparam logic [2:0] ERR_NOBURST  = 3'd5;

  typedef struct packed {
    logic openBank;
    logic closeBank;
    logic closeAll;
    logic markPre;
    logic markMode;
    logic loadBurst;
    logic clearBurst;
  } stateStrobe_t;

endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic                 addr10,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 initDone,
  input  logic                 burstActive,
  output stateStrobe_t         str,
  output logic                 repValid,
  output logic [2:0]           repKind,
  output logic [BANK_W-1:0]    repBank,
  output logic                 repA10,
  output logic [2:0]           repCode
);

  cmdKind_e kind;
  logic     tgtOpen;

  always_comb begin
    if (csN) kind = KIND_IDLE;
    else begin
      unique case ({rasN, casN, weN})
        3'b111:  kind = KIND_IDLE;
        3'b110:  kind = KIND_BSTOP;
        3'b101:  kind = KIND_READ;
        3'b100:  kind = KIND_WRITE;
        3'b011:  kind = KIND_ACT;
        3'b010:  kind = KIND_PRE;
        3'b000:  kind = KIND_MODE;
        default: kind = KIND_OTHER;
      endcase
    end
  end

  assign tgtOpen = bankOpen[bankAddr];

  always_comb begin
    str      = '0;
    repValid = cke;
    repKind  = '0;
    repBank  = '0;
    repA10   = 1'b0;
    repCode  = ERR_NONE;
    if (cke) begin
      repKind = kind;
      unique case (kind)
        KIND_ACT: begin
          repBank = bankAddr;
          if (!initDone)    repCode = ERR_NOINIT;
          else if (tgtOpen) repCode = ERR_OPEN;
          else              str.openBank = 1'b1;
        end
        KIND_READ, KIND_WRITE: begin
          repBank = bankAddr;
          repA10  = addr10;
          if (!initDone)     repCode = ERR_NOINIT;
          else if (!tgtOpen) repCode = ERR_CLOSED;
          else begin
            str.closeBank  = addr10;
            str.loadBurst  = (kind == KIND_READ);
            str.clearBurst = (kind == KIND_WRITE);
          end
        end
        KIND_PRE: begin
          repBank      = addr10 ? '0 : bankAddr;
          repA10       = addr10;
          str.closeAll  = addr10;
          str.closeBank = !addr10;
          str.markPre   = 1'b1;
        end
        KIND_MODE: begin
          if ((|bankOpen) || burstActive) repCode = ERR_MODEBUSY;
          else                            str.markMode = 1'b1;
        end
        KIND_BSTOP: begin
          if (!burstActive) repCode = ERR_NOBURST;
          else              str.clearBurst = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R5: a legal column access always targets an open bank
  a_r5_access_open: assert property (@(posedge clk) disable iff (!rstN)
    (str.loadBurst || (cke && kind == KIND_WRITE && repCode == ERR_NONE)) |-> tgtOpen);

  // R6: an activate is only allowed to open a closed bank
  a_r6_open_closed_only: assert property (@(posedge clk) disable iff (!rstN)
    str.openBank |-> !tgtOpen);

endmodule

// File: rtl/sdram_cmd_dp.sv
module sdram_cmd_dp
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BL_W      = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stateStrobe_t         str,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic [BL_W-1:0]      burstLen,
  input  logic                 repValid,
  input  logic [2:0]           repKind,
  input  logic [BANK_W-1:0]    repBank,
  input  logic                 repA10,
  input  logic [2:0]           repCode,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 initDone,
  output logic                 burstActive,
  output logic                 cmdValid,
  output logic [2:0]           cmdKind,
  output logic [BANK_W-1:0]    cmdBank,
  output logic                 cmdA10,
  output logic                 errPulse,
  output logic [2:0]           errCode
);

  logic            seenPre, seenMode;
  logic [BL_W-1:0] burstCnt;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic hit;
    assign hit = (bankAddr == BANK_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN)                        bankOpen[g] <= 1'b0;
      else if (str.closeAll)            bankOpen[g] <= 1'b0;
      else if (str.openBank && hit)     bankOpen[g] <= 1'b1;
      else if (str.closeBank && hit)    bankOpen[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenPre  <= 1'b0;
      seenMode <= 1'b0;
      burstCnt <= '0;
    end else begin
      if (str.markPre)  seenPre  <= 1'b1;
      if (str.markMode) seenMode <= 1'b1;
      if (str.loadBurst)        burstCnt <= burstLen;
      else if (str.clearBurst)  burstCnt <= '0;
      else if (burstCnt != '0)  burstCnt <= burstCnt - 1'b1;
    end
  end

  assign initDone    = seenPre && seenMode;
  assign burstActive = (burstCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdKind  <= '0;
      cmdBank  <= '0;
      cmdA10   <= 1'b0;
      errPulse <= 1'b0;
      errCode  <= '0;
    end else begin
      cmdValid <= repValid;
      cmdKind  <= repKind;
      cmdBank  <= repBank;
      cmdA10   <= repA10;
      errPulse <= (repCode != ERR_NONE);
      errCode  <= repCode;
    end
  end

  // R10: a flagged command leaves every bank as it was
  a_r10_err_keeps_banks: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> bankOpen == $past(bankOpen));

  // R4: an accepted activate implies initialization had completed
  a_r4_act_after_init: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == KIND_ACT && !errPulse) |-> $past(initDone));

  // R9: an all-bank precharge leaves no bank open
  a_r9_all_closed: assert property (@(posedge clk) disable iff (!rstN)
    str.closeAll |=> bankOpen == '0);

  // R8: without a reload the burst counter only moves down
  a_r8_burst_falls: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && !str.loadBurst) |=> burstCnt < $past(burstCnt));

  // R11: no error can be reported for a cycle with clock enable low
  a_r11_cke_low_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> !errPulse);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BL_W      = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] bankAddr,
  input  logic              addr10,
  input  logic [BL_W-1:0]   burstLen,
  output logic              cmdValid,
  output logic [2:0]        cmdKind,
  output logic [BANK_W-1:0] cmdBank,
  output logic              cmdA10,
  output logic              errPulse,
  output logic [2:0]        errCode
);

  stateStrobe_t         str;
  logic [NUM_BANKS-1:0] bankOpen;
  logic                 initDone, burstActive;
  logic                 repValid, repA10;
  logic [2:0]           repKind, repCode;
  logic [BANK_W-1:0]    repBank;

  sdram_cmd_ctrl #(.NUM_BANKS(NUM_BANKS)) uCtrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .addr10(addr10), .bankOpen(bankOpen),
    .initDone(initDone), .burstActive(burstActive), .str(str),
    .repValid(repValid), .repKind(repKind), .repBank(repBank),
    .repA10(repA10), .repCode(repCode)
  );

  sdram_cmd_dp #(.NUM_BANKS(NUM_BANKS), .BL_W(BL_W)) uDp (
    .clk(clk), .rstN(rstN), .str(str), .bankAddr(bankAddr), .burstLen(burstLen),
    .repValid(repValid), .repKind(repKind), .repBank(repBank), .repA10(repA10),
    .repCode(repCode), .bankOpen(bankOpen), .initDone(initDone),
    .burstActive(burstActive), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdBank(cmdBank), .cmdA10(cmdA10), .errPulse(errPulse), .errCode(errCode)
  );

  // R12: error pulse and reason code agree
  a_r12_code_matches: assert property (@(posedge clk) disable iff (!rstN)
    errPulse == (errCode != 3'd0));

endmodule

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [2:0] bankAddr = '0;
  logic addr10 = 1'b0;
  logic [3:0] burstLen = 4'd4;
  logic cmdValid, cmdA10, errPulse;
  logic [2:0] cmdKind, cmdBank, errCode;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor dut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .addr10(addr10), .burstLen(burstLen),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdBank(cmdBank),
    .cmdA10(cmdA10), .errPulse(errPulse), .errCode(errCode)
  );

  typedef struct {
    logic [2:0] kind;
    logic [2:0] bank;
    logic       valid;
    logic       a10;
    logic [2:0] code;
    string      req;
  } expItem_t;

  expItem_t sbQ[$];

  // behavioural model state
  bit mOpen[8];
  bit mPre, mMode;
  int mBurst;

  task automatic issue(input bit c, input bit cs, input bit ras, input bit cas,
                       input bit we, input int ba, input bit a, input string req);
    expItem_t e;
    bit active, ld, clr, anyOpen, init;
    e.valid = c; e.kind = 0; e.bank = 0; e.a10 = 0; e.code = 0; e.req = req;
    active = (mBurst > 0);
    ld = 0; clr = 0;
    init = mPre && mMode;
    anyOpen = 0;
    foreach (mOpen[i]) if (mOpen[i]) anyOpen = 1;
    if (c) begin
      if (cs) e.kind = 0;
      else case ({ras, cas, we})
        3'b111: e.kind = 0;
        3'b110: e.kind = 1;
        3'b101: e.kind = 2;
        3'b100: e.kind = 3;
        3'b011: e.kind = 4;
        3'b010: e.kind = 5;
        3'b000: e.kind = 6;
        default: e.kind = 7;
      endcase
      case (e.kind)
        4: begin
          e.bank = 3'(ba);
          if (!init) e.code = 1; else if (mOpen[ba]) e.code = 3;
          else mOpen[ba] = 1;
        end
        2, 3: begin
          e.bank = 3'(ba); e.a10 = a;
          if (!init) e.code = 1; else if (!mOpen[ba]) e.code = 2;
          else begin
            if (a) mOpen[ba] = 0;
            if (e.kind == 2) ld = 1; else clr = 1;
          end
        end
        5: begin
          e.a10 = a; e.bank = a ? 3'd0 : 3'(ba); mPre = 1;
          if (a) foreach (mOpen[i]) mOpen[i] = 0; else mOpen[ba] = 0;
        end
        6: if (anyOpen || active) e.code = 4; else mMode = 1;
        1: if (!active) e.code = 5; else clr = 1;
        default: ;
      endcase
    end
    if (ld) mBurst = int'(burstLen);
    else if (clr) mBurst = 0;
    else if (mBurst > 0) mBurst--;
    cke = c; csN = cs; rasN = ras; casN = cas; weN = we;
    bankAddr = 3'(ba); addr10 = a;
    @(posedge clk);
    sbQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic nop(input string r = "R1");  issue(1,0,1,1,1,0,0,r); endtask
  task automatic desel(input string r);       issue(1,1,0,0,0,5,1,r); endtask
  task automatic act(input int b, input string r); issue(1,0,0,1,1,b,0,r); endtask
  task automatic rd(input int b, input bit ap, input string r); issue(1,0,1,0,1,b,ap,r); endtask
  task automatic wr(input int b, input bit ap, input string r); issue(1,0,1,0,0,b,ap,r); endtask
  task automatic pre(input int b, input string r); issue(1,0,0,1,0,b,0,r); endtask
  task automatic pall(input int b, input string r); issue(1,0,0,1,0,b,1,r); endtask
  task automatic mode(input string r);        issue(1,0,0,0,0,0,0,r); endtask
  task automatic bst(input string r);         issue(1,0,1,1,0,0,0,r); endtask

  // monitor: compares each report one cycle after its edge
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      expItem_t e;
      e = sbQ.pop_front();
      checks++;
      if (cmdValid !== e.valid || cmdKind !== e.kind || cmdBank !== e.bank ||
          cmdA10 !== e.a10 || errCode !== e.code || errPulse !== (e.code != 0)) begin
        errors++;
        $display("FAIL %s: got v=%0b k=%0d b=%0d a=%0b e=%0b c=%0d exp v=%0b k=%0d b=%0d a=%0b c=%0d",
                 e.req, cmdValid, cmdKind, cmdBank, cmdA10, errPulse, errCode,
                 e.valid, e.kind, e.bank, e.a10, e.code);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    foreach (mOpen[i]) mOpen[i] = 0;
    mPre = 0; mMode = 0; mBurst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    checks++;
    if ({cmdValid, cmdKind, cmdBank, cmdA10, errPulse, errCode} !== '0) begin
      errors++;
      $display("FAIL R12 reset: got %b exp 0",
               {cmdValid, cmdKind, cmdBank, cmdA10, errPulse, errCode});
    end
    rstN = 1'b1;
    nop("R1 idle");
    desel("R2 deselect idle class");
    issue(1,0,0,0,1,2,0,"R1 other pattern unflagged");
    act(0, "R4 activate before init");        // code 1
    rd(0, 0, "R4 read before init");          // code 1
    pre(3, "R3 single precharge pre-init");
    act(1, "R4 activate before mode set");    // code 1
    mode("R7 mode set all closed");
    rd(0, 0, "R10 illegal act left bank0 closed"); // code 2
    act(2, "R9 activate bank2");
    act(2, "R6 activate open bank");          // code 3
    rd(5, 0, "R5 read closed bank");          // code 2
    mode("R7 mode set with bank open");       // code 4
    bst("R8 burst stop without burst");       // code 5
    // burst stop on last active edge
    rd(2, 0, "R8 read starts burst");
    nop(); nop(); nop();
    bst("R8 burst stop on last edge legal");
    rd(2, 0, "R8 read second burst");
    nop(); nop(); nop(); nop();
    bst("R8 burst stop after window");        // code 5
    // auto-precharge read then mode set during burst
    rd(2, 1, "R9 read auto-precharge");
    mode("R7 mode set during burst");         // code 4
    rd(2, 0, "R9 bank closed by auto-precharge"); // code 2
    nop(); nop();
    mode("R7 mode set after burst");
    // write ends burst
    act(3, "R9 activate bank3");
    rd(3, 0, "R8 read bank3");
    wr(3, 0, "R8 write ends burst");
    bst("R8 burst stop after write");         // code 5
    // all-bank precharge
    act(1, "R9 activate bank1");
    act(6, "R9 activate bank6");
    pall(7, "R3 all-bank precharge bank ignored");
    rd(1, 0, "R9 bank1 closed by all precharge");  // code 2
    wr(6, 0, "R9 bank6 closed by all precharge");  // code 2
    // write auto-precharge
    act(4, "R9 activate bank4");
    wr(4, 1, "R9 write auto-precharge");
    wr(4, 0, "R9 bank4 closed after write-ap");    // code 2
    pre(3, "R9 precharge bank3");
    rd(3, 0, "R9 bank3 closed by precharge");      // code 2
    // clock enable low
    issue(0,0,0,1,1,0,0,"R11 activate with cke low");
    rd(0, 0, "R11 bank0 still closed");            // code 2
    act(0, "R11 activate bank0 now legal");
    nop(); nop();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule